// File: doc/BRIEF.md
# Fractional Clock Rate Controller

This block derives two clock enables from one parent clock. Each output fires at a programmable fraction of the parent rate: a multiplier between 1 and 32 is applied as mult/32, and the result is then halved by a fixed divide-by-two. Each output has its own phase accumulator. The accumulator adds the multiplier on every parent cycle and raises a pulse on each carry-out. A toggle stage then passes every second one of those pulses.

Software uses a small register port. A ratio register holds one 5-bit field per output. A field stores 32 minus the multiplier, so a field of zero means full rate. Writing the ratio register only stages a setting. Software applies it by setting a commit bit in a separate command register. Each channel adopts the staged value the next time its accumulator phase is zero. Hardware clears the commit bit on the cycle after all channels have loaded. Software polls that bit to learn that the change is complete. While the commit bit is set, the ratio register refuses writes.

Top module: `frc_ctrl`

## Requirements
- R1: After reset the ratio register (address 1) reads 0, the command register (address 0) reads 0, and both outputs run at full rate: 32 pulses in any 64 consecutive parent cycles.
- R2: The primary field sits in bits 12:8 and the secondary field in bits 4:0 of the ratio register. A read returns the stored fields and 0 in every other bit.
- R3: With an applied field value f, an output gives exactly 32−f pulses in any 64 consecutive parent cycles, so its rate is parent × (32−f)/32 / 2.
- R4: No output enable is high on two consecutive parent cycles, and every output pulse follows a pulse of its fractional stage.
- R5: A write to the ratio register with no commit leaves both output rates unchanged.
- R6: Writing 1 to bit 31 of the command register sets the commit bit, and bit 31 then reads 1.
- R7: Hardware clears the commit bit within 34 cycles of it being set, and the new ratios are in effect from then on.
- R8: A ratio register write that arrives while the commit bit is set is dropped.
- R9: Writing 0 to bit 31 while a commit is pending does not cancel the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for both reads and writes |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for `addr`, combinational |
| en_pri | output | 1 | Primary output clock enable |
| en_sec | output | 1 | Secondary output clock enable |

## Verification
The hardest case to reach is a command-register access that lands while a commit is still pending. A commit can retire as early as two cycles after it is set, depending on where each accumulator phase happens to be. So the bench issues the cancelling write, and in a separate commit the refused ratio write, on the very next cycle after the commit lands. At that point the commit is certain to still be pending. Rates are measured by counting pulses over 64-cycle windows. These windows start only after the commit bit has cleared, so every count reflects a single ratio no matter where the window is aligned.

// File: rtl/frc_pkg.sv
package frc_pkg;
   localparam int FRC_NUM_CH = 2;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_RATIO = 2'd1,
      SEL_CMD   = 2'd2
   } frc_sel_e;

   function automatic int frc_lsb(input int ch, input int pri_lsb, input int sec_lsb);
      return (ch == 0) ? pri_lsb : sec_lsb;
   endfunction
endpackage

// File: rtl/frc_regs.sv
module frc_regs #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int FIELD_W    = 5,
   parameter int PRI_LSB    = 8,
   parameter int SEC_LSB    = 0,
   parameter int KICK_BIT   = 31,
   parameter int RATIO_ADDR = 1,
   parameter int CMD_ADDR   = 0,
   parameter int NUM_CH     = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [DATA_W-1:0]               wr_data,
   output logic [DATA_W-1:0]               rd_data,
   output logic [NUM_CH-1:0][FIELD_W-1:0]  ch_field,
   output logic                            kick,
   input  logic [NUM_CH-1:0]               ch_loaded
);
   import frc_pkg::*;

   localparam int FULL       = 1 << FIELD_W;
   localparam int KICK_LIMIT = FULL + 3;
   localparam int AGE_W      = $clog2(KICK_LIMIT + 2) + 1;

   frc_sel_e                     sel;
   logic [NUM_CH-1:0][FIELD_W-1:0] field_q;
   logic                         kick_q;
   logic                         all_loaded;
   logic [AGE_W-1:0]             age_q;

   always_comb begin
      sel = SEL_NONE;
      if (addr == ADDR_W'(RATIO_ADDR))
         sel = SEL_RATIO;
      else if (addr == ADDR_W'(CMD_ADDR))
         sel = SEL_CMD;
   end

   assign all_loaded = &ch_loaded;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         field_q <= '0;
      end else if (wr_en && sel == SEL_RATIO && !kick_q) begin
         for (int i = 0; i < NUM_CH; i++)
            field_q[i] <= wr_data[frc_lsb(i, PRI_LSB, SEC_LSB) +: FIELD_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         kick_q <= 1'b0;
      else if (kick_q && all_loaded)
         kick_q <= 1'b0;
      else if (wr_en && sel == SEL_CMD && wr_data[KICK_BIT])
         kick_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         age_q <= '0;
      else if (!kick_q)
         age_q <= '0;
      else if (age_q != {AGE_W{1'b1}})
         age_q <= age_q + 1'b1;
   end

   always_comb begin
      rd_data = '0;
      case (sel)
         SEL_RATIO: begin
            for (int i = 0; i < NUM_CH; i++)
               rd_data[frc_lsb(i, PRI_LSB, SEC_LSB) +: FIELD_W] = field_q[i];
         end
         SEL_CMD: rd_data[KICK_BIT] = kick_q;
         default: rd_data = '0;
      endcase
   end

   assign ch_field = field_q;
   assign kick     = kick_q;

   AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_RATIO && kick_q) |=> $stable(field_q)); // R8
   AST_KICK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (kick_q && !all_loaded) |=> kick_q); // R9
   AST_KICK_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      age_q <= AGE_W'(KICK_LIMIT)); // R7
endmodule

// File: rtl/frc_phase.sv
module frc_phase #(
   parameter int FIELD_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FIELD_W-1:0] field,
   input  logic               kick,
   output logic               loaded,
   output logic               frac_en
);
   localparam int STEP_W = FIELD_W + 1;
   localparam int FULL   = 1 << FIELD_W;

   logic [STEP_W-1:0]  step_q;
   logic [STEP_W-1:0]  step_now;
   logic [FIELD_W-1:0] phase_q;
   logic [STEP_W:0]    sum;
   logic               loaded_q;
   logic               load;

   assign load     = kick && !loaded_q && (phase_q == '0);
   assign step_now = load ? (STEP_W'(FULL) - STEP_W'(field)) : step_q;
   assign sum      = {2'b00, phase_q} + {1'b0, step_now};
   assign frac_en  = sum[FIELD_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q   <= STEP_W'(FULL);
         phase_q  <= '0;
         loaded_q <= 1'b0;
      end else begin
         phase_q <= sum[FIELD_W-1:0];
         if (load)
            step_q <= step_now;
         if (!kick)
            loaded_q <= 1'b0;
         else if (load)
            loaded_q <= 1'b1;
      end
   end

   assign loaded = loaded_q;

   AST_STEP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !kick |=> $stable(step_q)); // R5
   AST_FULL_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q == STEP_W'(FULL) && !kick) |-> frac_en); // R3
   AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q != '0 && step_q <= STEP_W'(FULL))); // R3
endmodule

// File: rtl/frc_halve.sv
module frc_halve (
   input  logic clk,
   input  logic rst_n,
   input  logic frac_en,
   output logic out_en
);
   logic tog_q;
   logic out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_q <= 1'b0;
         out_q <= 1'b0;
      end else begin
         out_q <= frac_en && tog_q;
         if (frac_en)
            tog_q <= !tog_q;
      end
   end

   assign out_en = out_q;

   AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      out_q |=> !out_q); // R4
   AST_OUT_FROM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      out_q |-> $past(frac_en)); // R4
endmodule

// File: rtl/frc_ctrl.sv
module frc_ctrl #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int FIELD_W    = 5,
   parameter int PRI_LSB    = 8,
   parameter int SEC_LSB    = 0,
   parameter int KICK_BIT   = 31,
   parameter int RATIO_ADDR = 1,
   parameter int CMD_ADDR   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              en_pri,
   output logic              en_sec
);
   import frc_pkg::*;

   localparam int NUM_CH = FRC_NUM_CH;

   if (PRI_LSB + FIELD_W > DATA_W || SEC_LSB + FIELD_W > DATA_W) begin : g_bad_field
      $error("ratio field exceeds register width");
   end
   if (!(PRI_LSB >= SEC_LSB + FIELD_W || SEC_LSB >= PRI_LSB + FIELD_W)) begin : g_bad_overlap
      $error("ratio fields overlap");
   end
   if (KICK_BIT >= DATA_W) begin : g_bad_kick
      $error("commit bit outside register");
   end
   if (RATIO_ADDR == CMD_ADDR || RATIO_ADDR >= (1 << ADDR_W) || CMD_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register addresses invalid");
   end
   if (NUM_CH != 2) begin : g_bad_ch
      $error("two channels expected");
   end

   logic [NUM_CH-1:0][FIELD_W-1:0] ch_field;
   logic [NUM_CH-1:0]              ch_loaded;
   logic [NUM_CH-1:0]              ch_frac;
   logic [NUM_CH-1:0]              ch_out;
   logic                           kick;

   frc_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W),
      .PRI_LSB(PRI_LSB), .SEC_LSB(SEC_LSB), .KICK_BIT(KICK_BIT),
      .RATIO_ADDR(RATIO_ADDR), .CMD_ADDR(CMD_ADDR), .NUM_CH(NUM_CH)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .ch_field(ch_field),
      .kick(kick), .ch_loaded(ch_loaded)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      frc_phase #(.FIELD_W(FIELD_W)) u_phase (
         .clk(clk), .rst_n(rst_n), .field(ch_field[c]), .kick(kick),
         .loaded(ch_loaded[c]), .frac_en(ch_frac[c])
      );
      frc_halve u_halve (
         .clk(clk), .rst_n(rst_n), .frac_en(ch_frac[c]), .out_en(ch_out[c])
      );
   end

   assign en_pri = ch_out[0];
   assign en_sec = ch_out[1];

   AST_KICK_CLEARS_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(kick) |-> $past(&ch_loaded)); // R7
endmodule

// File: tb/frc_ctrl_tb.sv
module frc_ctrl_tb;
   localparam int DW = 32;
   localparam int AW = 4;
   localparam logic [AW-1:0] A_RATIO = 4'd1;
   localparam logic [AW-1:0] A_CMD   = 4'd0;
   localparam logic [DW-1:0] KICK    = 32'h8000_0000;

   // vectors: {primary field, secondary field}
   localparam int NV = 6;
   localparam logic [9:0] VEC [NV] = '{
      {5'd0,  5'd0},
      {5'd16, 5'd8},
      {5'd31, 5'd1},
      {5'd1,  5'd31},
      {5'd5,  5'd20},
      {5'd24, 5'd0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          en_pri, en_sec;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   frc_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .en_pri(en_pri), .en_sec(en_sec)
   );

   task automatic check(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic count64(output int cp, output int cs);
      cp = 0; cs = 0;
      for (int i = 0; i < 64; i++) begin
         cp += int'(en_pri);
         cs += int'(en_sec);
         @(negedge clk);
      end
   endtask

   task automatic wait_clear(output int n);
      logic [DW-1:0] d;
      n = 0;
      rd(A_CMD, d);
      while (d[31] && n < 60) begin
         @(negedge clk);
         n++;
         rd(A_CMD, d);
      end
   endtask

   function automatic logic [DW-1:0] pack(input logic [4:0] p, input logic [4:0] s);
      return {19'd0, p, 3'd0, s};
   endfunction

   initial begin
      logic [DW-1:0] d;
      int cp, cs, n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_RATIO, d); check("R1 ratio reset", d, 0);
      rd(A_CMD, d);   check("R1 cmd reset", d, 0);
      count64(cp, cs);
      check("R1 pri full rate", cp, 32);
      check("R1 sec full rate", cs, 32);

      for (int v = 0; v < NV; v++) begin
         logic [4:0] pf, sf;
         pf = VEC[v][9:5];
         sf = VEC[v][4:0];
         wr(A_RATIO, pack(pf, sf) | 32'hFFFF_E0E0);
         rd(A_RATIO, d); check("R2 readback", d, pack(pf, sf));
         wr(A_CMD, KICK);
         wait_clear(n);
         check("R7 commit clears in time", (n <= 34), 1);
         count64(cp, cs);
         check("R3 pri rate", cp, 32 - pf);
         check("R3 sec rate", cs, 32 - sf);
      end

      // R5: staged write without commit keeps rates (24,0 applied)
      wr(A_RATIO, pack(5'd2, 5'd3));
      rd(A_RATIO, d); check("R2 staged readback", d, pack(5'd2, 5'd3));
      count64(cp, cs);
      check("R5 pri unchanged", cp, 8);
      check("R5 sec unchanged", cs, 32);

      // R6 and R9
      wr(A_CMD, KICK);
      rd(A_CMD, d); check("R6 commit reads set", d[31], 1);
      wr(A_CMD, 32'h0);
      rd(A_CMD, d); check("R9 commit not cancelled", d[31], 1);
      wait_clear(n);
      check("R7 commit clears", (n <= 34), 1);
      count64(cp, cs);
      check("R7 pri new rate", cp, 30);
      check("R7 sec new rate", cs, 29);

      // R8: ratio write while pending is dropped
      wr(A_CMD, KICK);
      wr(A_RATIO, pack(5'd9, 5'd9));
      wait_clear(n);
      rd(A_RATIO, d); check("R8 write refused", d, pack(5'd2, 5'd3));
      count64(cp, cs);
      check("R8 pri rate kept", cp, 30);
      check("R8 sec rate kept", cs, 29);

      // R4: no back-to-back output pulses at full rate
      wr(A_RATIO, 32'h0);
      wr(A_CMD, KICK);
      wait_clear(n);
      begin
         int pairs;
         logic pp, ps;
         pairs = 0; pp = en_pri; ps = en_sec;
         for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if ((pp && en_pri) || (ps && en_sec)) pairs++;
            pp = en_pri; ps = en_sec;
         end
         check("R4 no consecutive pulses", pairs, 0);
      end

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule